// File: doc/BRIEF.md
# Four-Stage In-Order Instruction Pipeline with Branch Squash

This block is the control and datapath of a small in-order processor. Each instruction passes through four stages. The first stage fetches the instruction word at the program counter. The second decodes it and forms its effective address. The third reads the memory operand and the destination register. The fourth computes the result and writes it back. Instruction and data memory sit outside the block on two separate combinational read ports. Because they are separate, fetch and operand read never compete for one memory.

The instruction set has six operations: load, add, subtract, increment, unconditional branch and no-operation. A branch is resolved in the last stage. When it is taken, the three younger instructions behind it are squashed and fetch restarts at the target on the next cycle. A result produced in the execute stage is forwarded to the operand stage in the same cycle, so back-to-back dependent instructions need no stall. Every register write is shown on a retire port, so the architectural register state can be rebuilt from outside the block.

Top module: `pipe4_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 and ret_valid_o is 0. All stage valid bits and all registers are cleared.
- R2: In any cycle whose execute stage does not hold a taken branch, imem_addr_o advances by exactly one on the next cycle. This happens even while squashed slots drain.
- R3: After reset is released, the instruction at address 0 is on the retire port during the third cycle, counting the first rising edge as cycle one. The two earlier cycles show no retirement.
- R4: A branch (opcode 5) loads the program counter with its 8-bit target, so imem_addr_o equals the target in the next cycle. The three following retire slots are empty, and the squashed instructions make no register write, including a second branch among them.
- R5: The instruction word is {op[13:10], rd[9:8], ea[7:0]}. The operations are: op 1 sets rd to mem[ea]; op 2 sets rd to rd+mem[ea]; op 3 sets rd to rd-mem[ea]; op 4 sets rd to rd+1; op 0 has no effect. Results wrap modulo 2^16. Each write appears on ret_valid_o, ret_rd_o and ret_data_o in the instruction's execute cycle.
- R6: An instruction that reads the register written by the instruction directly ahead of it uses that result.
- R7: Opcodes 6 to 15 act as no-operation: no register write and no change of control flow.
- R8: After a program containing taken branches, the register state rebuilt from the retire port equals that of a sequential, one-instruction-at-a-time execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | AW | Fetch address (program counter) |
| imem_data_i | input | IW | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | AW | Operand address of the operand-read stage |
| dmem_data_i | input | XLEN | Data word at dmem_addr_o, same cycle |
| ret_valid_o | output | 1 | A register write retires this cycle |
| ret_rd_o | output | RW | Destination register of the retiring write |
| ret_data_o | output | XLEN | Value written |

## Verification
The assertions assume that both memories return their word combinationally in the same cycle the address is presented. They also assume that every instruction word is fully defined, so the decoded opcode and branch target are never unknown. The bench models both memories as arrays driven by continuous assignment from the address ports. It fills every location with defined words and leaves unused instruction locations as no-operation, which keeps the stimulus within those assumptions. Two data sets are run through the same program, with a reset in mid-run between them, so that the flush, forwarding and reset paths are each exercised with different values.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_NOP  = 4'd0;
  localparam logic [OP_W-1:0] OP_LOAD = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD  = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd3;
  localparam logic [OP_W-1:0] OP_INC  = 4'd4;
  localparam logic [OP_W-1:0] OP_BR   = 4'd5;

  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
  endfunction
endpackage

// File: rtl/pipe4_decode.sv
module pipe4_decode
  import pipe4_pkg::*;
#(
  parameter int AW = 8,
  parameter int RW = 2,
  parameter int IW = OP_W + RW + AW
) (
  input  logic [IW-1:0]   instr_i,
  output logic [OP_W-1:0] op_o,
  output logic [RW-1:0]   rd_o,
  output logic [AW-1:0]   ea_o
);
  // direct addressing: effective address is the address field
  assign op_o = instr_i[IW-1 -: OP_W];
  assign rd_o = instr_i[RW+AW-1 -: RW];
  assign ea_o = instr_i[AW-1:0];
endmodule

// File: rtl/pipe4_regfile.sv
module pipe4_regfile #(
  parameter int XLEN = 16,
  parameter int NREG = 4,
  parameter int RW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic [RW-1:0]   ra_i,
  output logic [XLEN-1:0] rd_o
);
  logic [XLEN-1:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && (wa_i == RW'(g)))       mem_q[g] <= wd_i;
    end
  end

  assign rd_o = mem_q[ra_i];

  // R8
  rf_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/pipe4_alu.sv
module pipe4_alu
  import pipe4_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_LOAD: res_o = b_i;
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_INC:  res_o = a_i + XLEN'(1);
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
  import pipe4_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int AW   = 8,
  parameter int NREG = 4,
  parameter int RW   = $clog2(NREG),
  parameter int IW   = OP_W + RW + AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [AW-1:0]   imem_addr_o,
  input  logic [IW-1:0]   imem_data_i,
  output logic [AW-1:0]   dmem_addr_o,
  input  logic [XLEN-1:0] dmem_data_i,
  output logic            ret_valid_o,
  output logic [RW-1:0]   ret_rd_o,
  output logic [XLEN-1:0] ret_data_o
);
  logic [AW-1:0]   pc_q;
  // DA stage
  logic            da_v;
  logic [IW-1:0]   da_ir;
  logic [OP_W-1:0] dec_op;
  logic [RW-1:0]   dec_rd;
  logic [AW-1:0]   dec_ea;
  // FO stage
  logic            fo_v;
  logic [OP_W-1:0] fo_op;
  logic [RW-1:0]   fo_rd;
  logic [AW-1:0]   fo_ea;
  logic [XLEN-1:0] rf_rdata, fo_a;
  // EX stage
  logic            ex_v;
  logic [OP_W-1:0] ex_op;
  logic [RW-1:0]   ex_rd;
  logic [AW-1:0]   ex_ea;
  logic [XLEN-1:0] ex_a, ex_b, ex_res;
  logic            ex_wr, br_taken, fwd;

  assign imem_addr_o = pc_q;

  pipe4_decode #(.AW(AW), .RW(RW), .IW(IW)) u_dec (
    .instr_i(da_ir), .op_o(dec_op), .rd_o(dec_rd), .ea_o(dec_ea)
  );

  assign dmem_addr_o = fo_ea;

  pipe4_regfile #(.XLEN(XLEN), .NREG(NREG), .RW(RW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(ex_wr), .wa_i(ex_rd), .wd_i(ex_res),
    .ra_i(fo_rd), .rd_o(rf_rdata)
  );

  // EX result bypasses the register file write of the same edge
  assign fwd  = ex_wr && (ex_rd == fo_rd);
  assign fo_a = fwd ? ex_res : rf_rdata;

  pipe4_alu #(.XLEN(XLEN)) u_alu (
    .op_i(ex_op), .a_i(ex_a), .b_i(ex_b), .res_o(ex_res)
  );

  assign ex_wr    = ex_v && op_writes(ex_op);
  assign br_taken = ex_v && (ex_op == OP_BR);

  assign ret_valid_o = ex_wr;
  assign ret_rd_o    = ex_rd;
  assign ret_data_o  = ex_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      da_v  <= 1'b0;
      da_ir <= '0;
      fo_v  <= 1'b0;
      fo_op <= OP_NOP;
      fo_rd <= '0;
      fo_ea <= '0;
      ex_v  <= 1'b0;
      ex_op <= OP_NOP;
      ex_rd <= '0;
      ex_ea <= '0;
      ex_a  <= '0;
      ex_b  <= '0;
    end else begin
      pc_q  <= br_taken ? ex_ea : pc_q + AW'(1);
      da_v  <= !br_taken;
      da_ir <= imem_data_i;
      fo_v  <= da_v && !br_taken;
      fo_op <= dec_op;
      fo_rd <= dec_rd;
      fo_ea <= dec_ea;
      ex_v  <= fo_v && !br_taken;
      ex_op <= fo_op;
      ex_rd <= fo_rd;
      ex_ea <= fo_ea;
      ex_a  <= fo_a;
      ex_b  <= dmem_data_i;
    end
  end

  // R4
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |=> !da_v && !fo_v && !ex_v);
  // R4
  br_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |=> pc_q == $past(ex_ea));
  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_taken |=> pc_q == $past(pc_q) + AW'(1));
  // R6
  fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fo_v && ex_wr && (ex_rd == fo_rd)) |=> ex_a == $past(ex_res));
  // R5
  bubble_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_v |-> !ret_valid_o);
endmodule

// File: tb/tb_pipe4_core.sv
`timescale 1ns/1ps
module tb_pipe4_core;
  localparam int XLEN = 16, AW = 8, NREG = 4, RW = 2, IW = 14;
  localparam time CYC = 20ns;
  localparam int NSLOTS = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] imem_addr, dmem_addr;
  logic [IW-1:0] imem_data;
  logic [XLEN-1:0] dmem_data, ret_data;
  logic ret_valid;
  logic [RW-1:0] ret_rd;

  logic [IW-1:0]   imem [256];
  logic [XLEN-1:0] dmem [256];

  assign imem_data = imem[imem_addr];
  assign dmem_data = dmem[dmem_addr];

  always #(CYC/2) clk = ~clk;

  pipe4_core dut (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_data_i(dmem_data),
    .ret_valid_o(ret_valid), .ret_rd_o(ret_rd), .ret_data_o(ret_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // expected per-cycle retire slots
  bit              q_v[$];
  int              q_rd[$];
  logic [XLEN-1:0] q_dat[$];
  bit              q_br[$];
  int              q_tgt[$];
  string           q_tag[$];
  logic [XLEN-1:0] ref_regs [NREG];
  logic [XLEN-1:0] shadow [NREG];

  function automatic logic [IW-1:0] enc(int op, int rd, int ea);
    return {op[3:0], rd[1:0], ea[7:0]};
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(bit v, int rd, logic [XLEN-1:0] d, bit br, int tgt, string tag);
    q_v.push_back(v); q_rd.push_back(rd); q_dat.push_back(d);
    q_br.push_back(br); q_tgt.push_back(tgt); q_tag.push_back(tag);
  endtask

  // sequential execution, one slot per instruction, bubbles for fill and branch
  task automatic build_ref(int nslots);
    int pc = 0;
    int last_wr = -1;
    q_v.delete(); q_rd.delete(); q_dat.delete();
    q_br.delete(); q_tgt.delete(); q_tag.delete();
    for (int i = 0; i < NREG; i++) ref_regs[i] = '0;
    push(0, 0, '0, 0, 0, "R3");
    push(0, 0, '0, 0, 0, "R3");
    while (q_v.size() < nslots) begin
      logic [IW-1:0] w = imem[pc];
      int op = int'(w[13:10]);
      int rd = int'(w[9:8]);
      int ea = int'(w[7:0]);
      logic [XLEN-1:0] r;
      string tag = (last_wr == rd && op >= 2 && op <= 4) ? "R6" : "R5";
      if (op >= 1 && op <= 4) begin
        case (op)
          1: r = dmem[ea];
          2: r = ref_regs[rd] + dmem[ea];
          3: r = ref_regs[rd] - dmem[ea];
          default: r = ref_regs[rd] + 16'd1;
        endcase
        ref_regs[rd] = r;
        push(1, rd, r, 0, 0, tag);
        last_wr = rd;
        pc = (pc + 1) % 256;
      end else if (op == 5) begin
        push(0, 0, '0, 1, ea, "R4");
        push(0, 0, '0, 0, 0, "R4");
        push(0, 0, '0, 0, 0, "R4");
        push(0, 0, '0, 0, 0, "R4");
        last_wr = -1;
        pc = ea;
      end else begin
        push(0, 0, '0, 0, 0, (op == 0) ? "R5" : "R7");
        last_wr = -1;
        pc = (pc + 1) % 256;
      end
    end
  endtask

  task automatic run_prog(int nslots);
    logic [AW-1:0] prev_pc;
    bit prev_br;
    int prev_tgt;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 0, "R1", "reset pc", imem_addr, 0);
    chk(ret_valid == 0, "R1", "reset retire", ret_valid, 0);
    for (int i = 0; i < NREG; i++) shadow[i] = '0;
    build_ref(nslots);
    for (int i = 0; i < NREG; i++) ref_regs[i] = '0;
    rst_n = 1'b1;
    prev_pc = imem_addr; prev_br = 0; prev_tgt = 0;
    for (int k = 0; k < nslots; k++) begin
      bit v; int rd; logic [XLEN-1:0] d; bit br; int tgt; string tag;
      @(posedge clk);
      @(negedge clk);
      v = q_v.pop_front(); rd = q_rd.pop_front(); d = q_dat.pop_front();
      br = q_br.pop_front(); tgt = q_tgt.pop_front(); tag = q_tag.pop_front();
      if (prev_br) chk(imem_addr == AW'(prev_tgt), "R4", "fetch target", imem_addr, prev_tgt);
      else chk(imem_addr == prev_pc + AW'(1), "R2", "pc step", imem_addr, prev_pc + 1);
      chk(ret_valid == v, tag, "retire valid", ret_valid, v);
      if (v && ret_valid) begin
        chk(ret_rd == RW'(rd), tag, "retire rd", ret_rd, rd);
        chk(ret_data == d, tag, "retire data", ret_data, d);
      end
      if (v) ref_regs[rd] = d;
      if (ret_valid) shadow[ret_rd] = ret_data;
      prev_pc = imem_addr; prev_br = br; prev_tgt = tgt;
    end
    for (int i = 0; i < NREG; i++)
      chk(shadow[i] == ref_regs[i], "R8", $sformatf("final r%0d", i), shadow[i], ref_regs[i]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin imem[i] = '0; dmem[i] = '0; end
    imem[0]  = enc(1, 0, 1);
    imem[1]  = enc(2, 0, 2);
    imem[2]  = enc(4, 1, 0);
    imem[3]  = enc(3, 0, 3);
    imem[4]  = enc(5, 0, 8);
    imem[5]  = enc(4, 2, 0);
    imem[6]  = enc(4, 2, 0);
    imem[7]  = enc(4, 3, 0);
    imem[8]  = enc(4, 1, 0);
    imem[9]  = enc(1, 2, 4);
    imem[10] = enc(5, 0, 13);
    imem[11] = enc(4, 3, 0);
    imem[12] = enc(4, 3, 0);
    imem[13] = enc(3, 2, 1);
    imem[14] = enc(4, 2, 0);
    imem[15] = enc(0, 0, 0);
    imem[16] = enc(15, 3, 9);
    imem[17] = enc(4, 3, 0);
    imem[18] = enc(5, 0, 20);
    imem[19] = enc(5, 0, 5);
    imem[20] = enc(4, 3, 0);
    imem[21] = enc(5, 0, 21);
    dmem[1] = 16'd5; dmem[2] = 16'd7; dmem[3] = 16'd2; dmem[4] = 16'd100;
    run_prog(NSLOTS);
    // second data set; reset lands mid-loop
    dmem[1] = 16'hFFFF; dmem[2] = 16'd3; dmem[3] = 16'd9; dmem[4] = 16'h8000;
    run_prog(NSLOTS);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule